// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Two-Wire Register Slave

This block is the serial control front end of a dual-channel, 256-step digital potentiometer. A fast system clock oversamples the two-wire bus lines (SCL and SDA). The block finds START and STOP conditions and recognises its own 7-bit address, of which the low two bits come from strap pins. It keeps two 8-bit wiper codes, one shutdown flag and two general-purpose logic outputs. It drives SDA only through an open-drain pull-low enable.

A write transaction carries a command byte that picks the channel, can request a return to midscale, sets or clears shutdown and loads the two logic outputs. Data bytes follow the command, and each one reloads the chosen channel's wiper code. A read transaction has no command byte. It returns the code of whichever channel the last command picked, and it returns that byte again each time the master acknowledges. An asynchronous active-low shutdown pin and the shutdown flag both put each channel in shutdown. Neither of them touches the stored codes.

Top module: `digipot_i2c_slave`

## Requirements
- R1: After reset both wiper codes read 0x80, gpOut is 00, offA and offB are low, and sdaPullLow is low.
- R2: The address byte is matched MSB first against 0,1,0,1,1, then addrPins[1], then addrPins[0]. Its last bit is the direction: 1 means read and 0 means write. On a match the slave pulls SDA low during the ninth clock. On a mismatch SDA stays released.
- R3: After an address mismatch the slave neither acknowledges nor changes any register until the next START or STOP.
- R4: The slave changes SDA only while SCL is low. A falling SDA with SCL high is START, and a rising SDA with SCL high is STOP. STOP returns the slave to idle with SDA released.
- R5: In a write, the command byte and every data byte are acknowledged. A data byte goes into the wiper code of the channel that command bit 7 names (0 = channel A, 1 = channel B).
- R6: Command bit 4 drives gpOut[1] and bit 3 drives gpOut[0]. Bit 5 set raises both offA and offB. Bits 2..0 have no effect.
- R7: Shutdown, whether from sleepReqN low or from the command flag, never alters either wiper code. Once shutdown is released, the outputs show the earlier codes. A data byte committed while the pin is low is still stored.
- R8: Command bit 6 set loads 0x80 into the selected channel when the command byte is acknowledged. Data bytes that follow in the same transaction are acknowledged and discarded.
- R9: A read returns the last-selected channel's code MSB first. A master acknowledge repeats the byte. A master NACK leaves SDA released until STOP.
- R10: Several data bytes after one command each update the same channel, with no new address or command.
- R11: A pulse shorter than FILT_LEN system clocks on SCL or SDA is ignored. This covers a false STOP while SCL is high and an extra SCL high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as sensed |
| sdaIn | input | 1 | Bus data line as sensed |
| addrPins | input | 2 | Strap pins for the two low address bits |
| sleepReqN | input | 1 | Asynchronous active-low shutdown request |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| wiperCodeA | output | 8 | Wiper code of channel A |
| wiperCodeB | output | 8 | Wiper code of channel B |
| offA | output | 1 | Effective shutdown of channel A |
| offB | output | 1 | Effective shutdown of channel B |
| gpOut | output | 2 | Latched general-purpose logic outputs |

## Verification
The asynchronous shutdown request and a wiper-code commit can land in the same cycle. The bench provokes this by holding sleepReqN low across the whole data byte and its acknowledge clock, so the commit strobe fires while shutdown is active. It then judges the outcome from the ports: the new code must appear while offB stays high, and the code must survive after the pin is released. A midscale command and a later data byte also compete for one wiper register. Here the bench checks that the acknowledge still comes back while the code stays at 0x80.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_CH = 2;
  localparam logic [BYTE_W-1:0] MID_CODE = 8'h80;

  typedef struct packed {
    logic              instrLoad;
    logic              dataLoad;
    logic [BYTE_W-1:0] rxByte;
  } pot_strobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_INSTR, S_INSTR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RDATA_ACK, S_IGNORE
  } bus_state_t;
endpackage

// File: rtl/pot_line_filter.sv
module pot_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      cleanOut <= 1'b1;
      runCnt   <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CNT_W'(FILT_LEN - 1)) begin
        cleanOut <= syncB;
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pot_bus_ctrl.sv
module pot_bus_ctrl
  import potctl_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3,
  parameter logic [4:0]  ADDR_HI  = 5'b01011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        addrPins,
  input  logic [BYTE_W-1:0] rdCode,
  output pot_strobe_t       strobe,
  output logic              sdaPullLow
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(BYTE_W);

  logic [1:0] rawLines, cleanLines;
  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    pot_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end

  logic sclF, sdaF, sclQ, sdaQ;
  assign sclF = cleanLines[1];
  assign sdaF = cleanLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;

  bus_state_t        state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg, txReg;
  logic              sdaLow, readMode, masterAck;

  assign sdaPullLow = sdaLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txReg     <= '0;
      sdaLow    <= 1'b0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      strobe    <= '0;
    end else begin
      strobe.instrLoad <= 1'b0;
      strobe.dataLoad  <= 1'b0;
      if (startDet) begin
        state  <= S_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        state  <= S_IDLE;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_INSTR, S_WDATA: begin
            if (sclRise && bitCnt != BYTE_BITS) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaF};
              bitCnt   <= bitCnt + CNT_W'(1);
            end else if (sclFall && bitCnt == BYTE_BITS) begin
              bitCnt <= '0;
              if (state == S_ADDR) begin
                if (shiftReg[BYTE_W-1:1] == {ADDR_HI, addrPins}) begin
                  sdaLow   <= 1'b1;
                  readMode <= shiftReg[0];
                  state    <= S_ADDR_ACK;
                end else begin
                  state <= S_IGNORE;
                end
              end else begin
                sdaLow           <= 1'b1;
                strobe.rxByte    <= shiftReg;
                strobe.instrLoad <= (state == S_INSTR);
                strobe.dataLoad  <= (state == S_WDATA);
                state            <= (state == S_INSTR) ? S_INSTR_ACK : S_WDATA_ACK;
              end
            end
          end
          S_ADDR_ACK: begin
            if (sclFall) begin
              if (readMode) begin
                txReg  <= rdCode;
                sdaLow <= ~rdCode[BYTE_W-1];
                bitCnt <= CNT_W'(1);
                state  <= S_RDATA;
              end else begin
                sdaLow <= 1'b0;
                state  <= S_INSTR;
              end
            end
          end
          S_INSTR_ACK, S_WDATA_ACK: begin
            if (sclFall) begin
              sdaLow <= 1'b0;
              state  <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (sclFall) begin
              if (bitCnt == BYTE_BITS) begin
                sdaLow <= 1'b0;
                state  <= S_RDATA_ACK;
              end else begin
                txReg  <= txReg << 1;
                sdaLow <= ~txReg[BYTE_W-2];
                bitCnt <= bitCnt + CNT_W'(1);
              end
            end
          end
          S_RDATA_ACK: begin
            if (sclRise) begin
              masterAck <= ~sdaF;
            end else if (sclFall) begin
              if (masterAck) begin
                txReg  <= rdCode;
                sdaLow <= ~rdCode[BYTE_W-1];
                bitCnt <= CNT_W'(1);
                state  <= S_RDATA;
              end else begin
                state <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE && !sdaLow)); // R4
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |-> (!sdaLow && !strobe.instrLoad && !strobe.dataLoad)); // R3
  AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && sclQ) |-> $stable(sdaLow)); // R4
endmodule

// File: rtl/pot_regfile.sv
module pot_regfile
  import potctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pot_strobe_t       strobe,
  input  logic              sleepReqN,
  output logic [NUM_CH-1:0][BYTE_W-1:0] wiperArr,
  output logic [BYTE_W-1:0] rdCode,
  output logic [NUM_CH-1:0] offVec,
  output logic [1:0]        gpOut
);
  logic chSel, shutFlag, midHold;
  logic unusedLowBits;
  assign unusedLowBits = ^strobe.rxByte[2:0];

  logic cmdSel, cmdMid;
  assign cmdSel = strobe.rxByte[7];
  assign cmdMid = strobe.rxByte[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chSel    <= 1'b0;
      shutFlag <= 1'b0;
      midHold  <= 1'b0;
      gpOut    <= 2'b00;
    end else if (strobe.instrLoad) begin
      chSel    <= cmdSel;
      midHold  <= cmdMid;
      shutFlag <= strobe.rxByte[5];
      gpOut    <= {strobe.rxByte[4], strobe.rxByte[3]};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic CH_ID = 1'(c);
    logic [BYTE_W-1:0] codeReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeReg <= MID_CODE;
      end else if (strobe.instrLoad && cmdMid && cmdSel == CH_ID) begin
        codeReg <= MID_CODE;
      end else if (strobe.dataLoad && !midHold && chSel == CH_ID) begin
        codeReg <= strobe.rxByte;
      end
    end
    assign wiperArr[c] = codeReg;
    assign offVec[c]   = shutFlag | ~sleepReqN;
  end

  assign rdCode = wiperArr[chSel];

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.instrLoad && strobe.dataLoad)); // R5
  AST_MID_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.instrLoad && cmdMid) |=> (rdCode == MID_CODE)); // R8
  AST_MID_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataLoad && midHold) |=> $stable(wiperArr)); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.instrLoad && !strobe.dataLoad) |=> $stable(wiperArr)); // R7
endmodule

// File: rtl/digipot_i2c_slave.sv
module digipot_i2c_slave
  import potctl_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        addrPins,
  input  logic              sleepReqN,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] wiperCodeA,
  output logic [BYTE_W-1:0] wiperCodeB,
  output logic              offA,
  output logic              offB,
  output logic [1:0]        gpOut
);
  pot_strobe_t strobe;
  logic [BYTE_W-1:0] rdCode;
  logic [NUM_CH-1:0][BYTE_W-1:0] wiperArr;
  logic [NUM_CH-1:0] offVec;

  pot_bus_ctrl #(.FILT_LEN(FILT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrPins(addrPins), .rdCode(rdCode), .strobe(strobe),
    .sdaPullLow(sdaPullLow)
  );

  pot_regfile u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sleepReqN(sleepReqN),
    .wiperArr(wiperArr), .rdCode(rdCode), .offVec(offVec), .gpOut(gpOut)
  );

  assign wiperCodeA = wiperArr[0];
  assign wiperCodeB = wiperArr[1];
  assign offA       = offVec[0];
  assign offB       = offVec[1];
endmodule

// File: tb/digipot_i2c_slave_test.sv
module digipot_i2c_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic mLow = 1'b0;
  logic [1:0] addrPins = 2'b00;
  logic sleepReqN = 1'b1;
  logic sdaPullLow, offA, offB;
  logic [7:0] wiperCodeA, wiperCodeB;
  logic [1:0] gpOut;
  logic sdaBus;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sdaBus = !(mLow || sdaPullLow);

  digipot_i2c_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .addrPins(addrPins), .sleepReqN(sleepReqN), .sdaPullLow(sdaPullLow),
    .wiperCodeA(wiperCodeA), .wiperCodeB(wiperCodeB),
    .offA(offA), .offB(offB), .gpOut(gpOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    mLow = 0; waitQ(); sclDrv = 1; waitQ(); mLow = 1; waitQ(); sclDrv = 0; waitQ();
  endtask

  task automatic busStop();
    mLow = 1; waitQ(); sclDrv = 1; waitQ(); mLow = 0; waitQ(2);
  endtask

  task automatic sendBit(input logic b);
    mLow = !b; waitQ(); sclDrv = 1; waitQ(2); sclDrv = 0; waitQ();
  endtask

  task automatic ackClock(output logic ack);
    mLow = 0; waitQ(); sclDrv = 1; waitQ(); ack = !sdaBus; waitQ(); sclDrv = 0; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackClock(ack);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    mLow = 0;
    for (int i = 7; i >= 0; i--) begin
      sclDrv = 1; waitQ(); b[i] = sdaBus; waitQ(); sclDrv = 0; waitQ(2);
    end
    mLow = ackIt; sclDrv = 1; waitQ(2); sclDrv = 0; waitQ(); mLow = 0; waitQ();
  endtask

  // data byte 0x3C with a false STOP pulse on bit 7 and an extra SCL pulse on bit 6
  task automatic glitchByte(output logic ack);
    mLow = 1; waitQ(); sclDrv = 1; waitQ();
    mLow = 0; @(negedge clk); mLow = 1;
    waitQ(); sclDrv = 0; waitQ();
    mLow = 1; repeat (3) @(negedge clk); sclDrv = 1; @(negedge clk); sclDrv = 0;
    repeat (4) @(negedge clk); sclDrv = 1; waitQ(2); sclDrv = 0; waitQ();
    for (int i = 5; i >= 0; i--) sendBit(8'h3C >> i);
    ackClock(ack);
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] p, input logic rd);
    return {5'b01011, p, rd};
  endfunction

  task automatic writeTx(input logic [7:0] instr, input logic [7:0] data, input bit withData,
                         input string req);
    logic ack;
    busStart();
    sendByte(addrByte(addrPins, 1'b0), ack); check({req, " addr ack"}, ack, 1);
    sendByte(instr, ack); check({req, " instr ack"}, ack, 1);
    if (withData) begin
      sendByte(data, ack); check({req, " data ack"}, ack, 1);
    end
    busStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    waitQ(2);
    rstN = 1;
    waitQ();
    // R1 reset state
    check("R1 wiperCodeA", wiperCodeA, 8'h80);
    check("R1 wiperCodeB", wiperCodeB, 8'h80);
    check("R1 gpOut", gpOut, 0);
    check("R1 offA/offB", {offA, offB}, 0);
    check("R1 sdaPullLow", sdaPullLow, 0);

    // R2 address sweep over strap pins and low address bits
    for (int p = 0; p < 4; p++) begin
      addrPins = 2'(p);
      for (int a = 0; a < 4; a++) begin
        busStart(); sendByte(addrByte(2'(a), 1'b0), ack); busStop();
        check("R2 address match ack", ack, (a == p) ? 1 : 0);
      end
      busStart(); sendByte({5'b01010, 2'(p), 1'b0}, ack); busStop();
      check("R2 wrong fixed prefix", ack, 0);
    end

    // R3 mismatch: no ack and no register change afterwards
    addrPins = 2'b01;
    busStart();
    sendByte(addrByte(2'b10, 1'b0), ack); check("R3 mismatch addr", ack, 0);
    sendByte(8'h18, ack); check("R3 instr after mismatch", ack, 0);
    sendByte(8'h33, ack); check("R3 data after mismatch", ack, 0);
    busStop();
    check("R3 wiperCodeA kept", wiperCodeA, 8'h80);
    check("R3 gpOut kept", gpOut, 0);

    // R5 write to channel A
    writeTx(8'h00, 8'h5A, 1, "R5");
    check("R5 wiperCodeA", wiperCodeA, 8'h5A);
    check("R5 wiperCodeB untouched", wiperCodeB, 8'h80);

    // R10 repeated data bytes to channel B in one transaction
    busStart();
    sendByte(addrByte(addrPins, 1'b0), ack); check("R10 addr ack", ack, 1);
    sendByte(8'h80, ack); check("R10 instr ack", ack, 1);
    for (int v = 0; v < 256; v += 5) begin
      sendByte(8'(v), ack);
      check("R10 repeat ack", ack, 1);
      check("R10 wiperCodeB", wiperCodeB, v);
    end
    busStop();
    check("R10 wiperCodeA untouched", wiperCodeA, 8'h5A);

    // R6 output latches, ignored low bits
    for (int g = 0; g < 4; g++) begin
      writeTx({3'b000, 2'(g), 3'b101}, 8'(8'h10 + g), 1, "R6");
      check("R6 gpOut", gpOut, g);
      check("R6 wiperCodeA", wiperCodeA, 8'h10 + g);
      check("R6 no shutdown", {offA, offB}, 0);
    end
    writeTx(8'h9F, 8'h21, 1, "R6");
    check("R6 gpOut bit4/bit3", gpOut, 3);
    check("R6 wiperCodeB", wiperCodeB, 8'h21);

    // R6/R7 shutdown flag keeps codes
    writeTx(8'h20, 8'h66, 1, "R6");
    check("R6 shutdown flag offA", offA, 1);
    check("R6 shutdown flag offB", offB, 1);
    check("R7 code while off", wiperCodeA, 8'h66);
    writeTx(8'h00, 8'h00, 0, "R7");
    check("R7 flag cleared", {offA, offB}, 0);
    check("R7 code restored A", wiperCodeA, 8'h66);
    check("R7 code restored B", wiperCodeB, 8'h21);

    // R7 pin shutdown coincident with a commit
    busStart();
    sendByte(addrByte(addrPins, 1'b0), ack);
    sendByte(8'h80, ack);
    sleepReqN = 0;
    @(negedge clk);
    check("R7 pin forces offA", offA, 1);
    check("R7 pin forces offB", offB, 1);
    sendByte(8'h77, ack);
    check("R7 ack during pin", ack, 1);
    busStop();
    check("R7 commit under pin", wiperCodeB, 8'h77);
    check("R7 still off", offB, 1);
    sleepReqN = 1;
    @(negedge clk);
    check("R7 pin released", {offA, offB}, 0);
    check("R7 code kept B", wiperCodeB, 8'h77);

    // R8 midscale with discarded data
    busStart();
    sendByte(addrByte(addrPins, 1'b0), ack);
    sendByte(8'hC0, ack); check("R8 instr ack", ack, 1);
    sendByte(8'h11, ack); check("R8 discarded data ack", ack, 1);
    sendByte(8'h22, ack); check("R8 second discarded ack", ack, 1);
    busStop();
    check("R8 wiperCodeB midscale", wiperCodeB, 8'h80);
    check("R8 wiperCodeA untouched", wiperCodeA, 8'h66);

    // R9 reads
    writeTx(8'h80, 8'hA5, 1, "R9");
    busStart();
    sendByte(addrByte(addrPins, 1'b1), ack); check("R9 read addr ack", ack, 1);
    readByte(1'b1, rd); check("R9 first read B", rd, 8'hA5);
    readByte(1'b0, rd); check("R9 repeat read B", rd, 8'hA5);
    sendBit(1'b1);
    check("R9 released after NACK", sdaPullLow, 0);
    busStop();
    writeTx(8'h00, 8'h00, 0, "R9");
    busStart();
    sendByte(addrByte(addrPins, 1'b1), ack);
    readByte(1'b0, rd); check("R9 read A", rd, 8'h66);
    busStop();
    check("R9 read leaves A", wiperCodeA, 8'h66);

    // R11 glitches filtered
    busStart();
    sendByte(addrByte(addrPins, 1'b0), ack);
    sendByte(8'h00, ack);
    glitchByte(ack); check("R11 ack despite glitches", ack, 1);
    busStop();
    check("R11 wiperCodeA", wiperCodeA, 8'h3C);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule